// File: doc/BRIEF.md
# Two-Wire Slave Register Window

This block is a slave on a two-wire serial bus (I2C-compatible signalling) that gives a bus master access to a 64-byte register space. The first eight bytes hold the clock and control fields and the rest is general RAM. The registers sit outside this block. The block reaches them through a plain internal port: an address, a write strobe with write data, and combinational read data.

The bus lines are sampled by a faster system clock. Each line passes through a two-flop synchronizer and a glitch filter before the block looks for START, STOP and clock edges. The block matches its 7-bit address and then follows the access.

- **Write access:** the first byte after the address loads a persistent byte pointer. Each later byte is written at the pointer.
- **Read access:** returns bytes from the pointer onward for as long as the master acknowledges.
- **Read without a word address:** continues from wherever the pointer was left.

The pointer only moves on acknowledge clocks. A power-fail input ends any access and clears the pointer.

Top module: `i2c_reg_slave`

## Requirements
- R1: The block acknowledges only the address bytes 0xD0 (write) and 0xD1 (read), that is 1101000 followed by the direction bit. After any other address byte it leaves SDA released until the next START, and it makes no register write.
- R2: In a write access, the first byte after the address byte loads the pointer with its low 6 bits, and `regAddr` shows the pointer.
- R3: Each later byte of a write access gives one `regWrEn` pulse with `regWrData` equal to the byte and `regAddr` equal to the pointer. The pointer advances by one only on the falling SCL edge that ends the acknowledge clock.
- R4: The block pulls SDA low during the acknowledge clock after a matching address byte, after the word-address byte and after every data byte it receives.
- R5: In a read access, the block sends the byte at the pointer, MSB first. It advances the pointer and sends the next byte only when the master acknowledges (SDA low on the ninth clock).
- R6: A missing acknowledge from the master ends the read. SDA is then released and the pointer stays at the address of the last byte sent.
- R7: A read access that is not preceded by a word address starts from the address the pointer holds, including after a STOP.
- R8: The pointer wraps from 63 to 0 on writes and on reads.
- R9: A repeated START, SDA falling while SCL is high, restarts the address phase at any point of an access.
- R10: A STOP, SDA rising while SCL is high, ends the access. A partly received byte is discarded and causes no write.
- R11: While `powerFail` is high, the block releases SDA, makes no register write, holds the pointer at 0 and ignores all bus activity.
- R12: A pulse on SDA or SCL shorter than FILT_LEN system clocks has no effect on the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Level of the SCL bus line |
| sdaIn | input | 1 | Level of the SDA bus line |
| sdaDriveLow | output | 1 | 1 pulls SDA low through the open-drain driver |
| powerFail | input | 1 | Supply out of tolerance; aborts and holds the block |
| regAddr | output | ADDR_W | Pointer, used as the register port address |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrData | output | 8 | Register write data |
| regRdData | input | 8 | Register read data for `regAddr` (combinational) |

## Verification
A power-fail can arrive in the same system cycle as the falling SCL edge that completes a data byte. That edge would otherwise raise the write strobe and move the controller into the acknowledge phase. The bench raises `powerFail` at the exact moment the master drops SCL after the eighth bit of a write, so the filtered edge lands while the abort is already active. It then judges the result at the ports: no write may appear in the register stand-in, the pointer must read 0, SDA must stay released, and a following current-address read must start at 0.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACKOUT,
    ST_LOAD,
    ST_SEND,
    ST_ACKIN
  } busState_t;

  typedef enum logic [1:0] {
    KIND_ADDR,
    KIND_WADDR,
    KIND_DATA
  } byteKind_t;

  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic clrCnt;
    logic loadPtr;
    logic incPtr;
    logic clrPtr;
  } dpStrobe_t;

endpackage

// File: rtl/i2c_bus_sense.sv
module i2c_bus_sense #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclRise,
  output logic sclFall,
  output logic sdaLevel,
  output logic startDet,
  output logic stopDet
);
  localparam int NLINES = 2;
  localparam int CNT_W  = $clog2(FILT_LEN + 1);

  logic [NLINES-1:0] rawBus;
  logic [NLINES-1:0] cleanBus;
  logic [NLINES-1:0] prevBus;

  assign rawBus = {sdaIn, sclIn};

  for (genvar g = 0; g < NLINES; g++) begin : gLine
    logic [1:0]       syncQ;
    logic [CNT_W-1:0] runCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ       <= 2'b11;
        runCnt      <= '0;
        cleanBus[g] <= 1'b1;
      end else begin
        syncQ <= {syncQ[0], rawBus[g]};
        if (syncQ[1] != cleanBus[g]) begin
          if (runCnt == CNT_W'(FILT_LEN - 1)) begin
            cleanBus[g] <= syncQ[1];
            runCnt      <= '0;
          end else begin
            runCnt <= runCnt + 1'b1;
          end
        end else begin
          runCnt <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevBus <= '1;
    else       prevBus <= cleanBus;
  end

  assign sclRise  = cleanBus[0] & ~prevBus[0];
  assign sclFall  = ~cleanBus[0] & prevBus[0];
  assign sdaLevel = cleanBus[1];
  assign startDet = ~cleanBus[1] & prevBus[1] & cleanBus[0] & prevBus[0];
  assign stopDet  = cleanBus[1] & ~prevBus[1] & cleanBus[0] & prevBus[0];
endmodule

// File: rtl/i2c_slave_dp.sv
module i2c_slave_dp
  import i2c_reg_pkg::*;
#(
  parameter int          ADDR_W     = 6,
  parameter logic [6:0]  SLAVE_ADDR = 7'h68
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              sdaBit,
  input  logic [BYTE_W-1:0] rdData,
  output logic              byteFull,
  output logic              addrHit,
  output logic              rwBit,
  output logic              txBit,
  output logic [BYTE_W-1:0] rxByte,
  output logic [ADDR_W-1:0] ptr
);
  localparam int BCNT_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] shiftQ;
  logic [BCNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      bitCnt <= '0;
    end else begin
      if (strobe.clrCnt) begin
        bitCnt <= '0;
      end else if (strobe.shiftIn || strobe.shiftOut) begin
        bitCnt <= bitCnt + 1'b1;
      end
      if (strobe.loadTx) begin
        shiftQ <= rdData;
      end else if (strobe.shiftIn) begin
        shiftQ <= {shiftQ[BYTE_W-2:0], sdaBit};
      end else if (strobe.shiftOut) begin
        shiftQ <= {shiftQ[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strobe.clrPtr) begin
      ptr <= '0;
    end else if (strobe.loadPtr) begin
      ptr <= shiftQ[ADDR_W-1:0];
    end else if (strobe.incPtr) begin
      ptr <= ptr + 1'b1;
    end
  end

  assign byteFull = (bitCnt == BCNT_W'(BYTE_W));
  assign rxByte   = shiftQ;
  assign addrHit  = (shiftQ[BYTE_W-1:1] == SLAVE_ADDR);
  assign rwBit    = shiftQ[0];
  assign txBit    = shiftQ[BYTE_W-1];
endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_reg_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startDet,
  input  logic      stopDet,
  input  logic      sdaBit,
  input  logic      powerFail,
  input  logic      byteFull,
  input  logic      addrHit,
  input  logic      rwBit,
  input  logic      txBit,
  output dpStrobe_t strobe,
  output logic      sdaDriveLow,
  output logic      regWrEn
);
  busState_t state, stateNx;
  byteKind_t kind, kindNx;
  logic      readMode, readModeNx;
  logic      masterAck, masterAckNx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kind      <= KIND_ADDR;
      readMode  <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= stateNx;
      kind      <= kindNx;
      readMode  <= readModeNx;
      masterAck <= masterAckNx;
    end
  end

  always_comb begin
    stateNx     = state;
    kindNx      = kind;
    readModeNx  = readMode;
    masterAckNx = masterAck;
    strobe      = '0;
    regWrEn     = 1'b0;
    if (powerFail) begin
      stateNx       = ST_IDLE;
      strobe.clrPtr = 1'b1;
    end else if (startDet) begin
      stateNx       = ST_RECV;
      kindNx        = KIND_ADDR;
      readModeNx    = 1'b0;
      strobe.clrCnt = 1'b1;
    end else if (stopDet) begin
      stateNx = ST_IDLE;
    end else begin
      unique case (state)
        ST_RECV: begin
          if (sclRise && !byteFull) begin
            strobe.shiftIn = 1'b1;
          end else if (sclFall && byteFull) begin
            stateNx = ST_ACKOUT;
            unique case (kind)
              KIND_ADDR: begin
                if (addrHit) readModeNx = rwBit;
                else         stateNx    = ST_IDLE;
              end
              KIND_WADDR: strobe.loadPtr = 1'b1;
              default:    regWrEn        = 1'b1;
            endcase
          end
        end
        ST_ACKOUT: begin
          if (sclFall) begin
            strobe.clrCnt = 1'b1;
            if (readMode) begin
              stateNx = ST_LOAD;
            end else begin
              stateNx = ST_RECV;
              if (kind == KIND_DATA) strobe.incPtr = 1'b1;
              kindNx = (kind == KIND_ADDR) ? KIND_WADDR : KIND_DATA;
            end
          end
        end
        ST_LOAD: begin
          strobe.loadTx = 1'b1;
          stateNx       = ST_SEND;
        end
        ST_SEND: begin
          if (byteFull) begin
            stateNx = ST_ACKIN;
          end else if (sclFall) begin
            strobe.shiftOut = 1'b1;
          end
        end
        ST_ACKIN: begin
          if (sclRise) begin
            masterAckNx = ~sdaBit;
          end else if (sclFall) begin
            if (masterAck) begin
              strobe.incPtr = 1'b1;
              strobe.clrCnt = 1'b1;
              stateNx       = ST_LOAD;
            end else begin
              stateNx = ST_IDLE;
            end
          end
        end
        default: stateNx = ST_IDLE;
      endcase
    end
  end

  assign sdaDriveLow = (state == ST_ACKOUT) ||
                       ((state == ST_SEND) && !byteFull && !txBit);
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_reg_pkg::*;
#(
  parameter int         ADDR_W     = 6,
  parameter int         FILT_LEN   = 3,
  parameter logic [6:0] SLAVE_ADDR = 7'h68
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  input  logic              powerFail,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  input  logic [BYTE_W-1:0] regRdData
);
  logic      sclRise, sclFall, sdaLevel, startDet, stopDet;
  logic      byteFull, addrHit, rwBit, txBit;
  dpStrobe_t strobe;

  i2c_bus_sense #(.FILT_LEN(FILT_LEN)) uSense (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclRise(sclRise), .sclFall(sclFall), .sdaLevel(sdaLevel),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2c_slave_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaLevel),
    .powerFail(powerFail), .byteFull(byteFull), .addrHit(addrHit),
    .rwBit(rwBit), .txBit(txBit), .strobe(strobe),
    .sdaDriveLow(sdaDriveLow), .regWrEn(regWrEn)
  );

  i2c_slave_dp #(.ADDR_W(ADDR_W), .SLAVE_ADDR(SLAVE_ADDR)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaBit(sdaLevel),
    .rdData(regRdData), .byteFull(byteFull), .addrHit(addrHit),
    .rwBit(rwBit), .txBit(txBit), .rxByte(regWrData), .ptr(regAddr)
  );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              powerFail,
  input logic              sdaDriveLow,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr
);
  // R11
  pf_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerFail |=> !sdaDriveLow);

  // R11
  pf_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerFail |-> !regWrEn);

  // R11
  pf_ptr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerFail |=> (regAddr == '0));

  // R4
  wr_then_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> sdaDriveLow);

  // R3
  wr_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> $stable(regAddr));
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .powerFail(powerFail),
  .sdaDriveLow(sdaDriveLow), .regWrEn(regWrEn), .regAddr(regAddr)
);

// File: tb/tb_i2c_reg_slave.sv
module tb_i2c_reg_slave;
  localparam int Q = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic       powerFail = 1'b0;
  logic       sdaDriveLow;
  logic [5:0] regAddr;
  logic       regWrEn;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic       sdaLine;

  logic [7:0] mem [64];
  logic [7:0] expMem [64];
  int         expPtr = 0;
  int         wrCount = 0;
  int         nChecks = 0;
  int         nFail = 0;

  always #5 clk = ~clk;

  assign sdaLine   = sdaM & ~sdaDriveLow;
  assign regRdData = mem[regAddr];

  i2c_reg_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .powerFail(powerFail), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData)
  );

  always @(posedge clk) begin
    if (regWrEn) begin
      mem[regAddr] <= regWrData;
      wrCount <= wrCount + 1;
    end
  end

  task automatic check(input string req, input int act, input int expv);
    nChecks++;
    if (act != expv) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    sdaM = 1'b0; waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(1);
    sclM = 1'b1; waitQ(1);
    sdaM = 1'b1; waitQ(1);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b;    waitQ(1);
    sclM = 1'b1; waitQ(2);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic getAck(output logic ack);
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    ack = ~sdaLine;
    waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    getAck(ack);
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ(1);
      sclM = 1'b1; waitQ(1);
      b[i] = sdaLine;
      waitQ(1);
      sclM = 1'b0;
    end
    waitQ(1);
    sendBit(~giveAck);
    sdaM = 1'b1;
  endtask

  task automatic doWrite(input int a, input int n);
    logic ack;
    logic [7:0] d;
    busStart();
    writeByte(8'hD0, ack); check("R1 write address ack", ack, 1);
    writeByte(8'(a), ack); check("R4 word address ack", ack, 1);
    expPtr = a % 64;
    check("R2 pointer load", regAddr, expPtr);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      writeByte(d, ack); check("R4 data ack", ack, 1);
      expMem[expPtr] = d;
      expPtr = (expPtr + 1) % 64;
    end
    busStop();
    check("R3/R8 pointer after write", regAddr, expPtr);
  endtask

  task automatic doRead(input int a, input int n, input logic setAddr);
    logic ack;
    logic [7:0] d;
    busStart();
    if (setAddr) begin
      writeByte(8'hD0, ack);
      writeByte(8'(a), ack);
      expPtr = a % 64;
      busStart();
    end
    writeByte(8'hD1, ack); check("R1/R9 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      readByte(i < n - 1, d);
      check(setAddr ? "R5 read data" : "R7 current-address read", d, expMem[expPtr]);
      if (i < n - 1) expPtr = (expPtr + 1) % 64;
    end
    check("R6 SDA released after NACK", sdaDriveLow, 0);
    check("R6 pointer held after NACK", regAddr, expPtr);
    busStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    logic ack;
    int   w0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) begin
      mem[i] = 8'h00;
      expMem[i] = 8'h00;
    end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R11 reset pointer", regAddr, 0);
    check("R4 reset SDA released", sdaDriveLow, 0);

    // R1: foreign address ignored
    w0 = wrCount;
    busStart();
    writeByte(8'hA0, ack); check("R1 foreign address NACK", ack, 0);
    writeByte(8'h05, ack); check("R1 ignored after mismatch", ack, 0);
    writeByte(8'h5A, ack); check("R1 ignored data", ack, 0);
    busStop();
    check("R1 no write after mismatch", wrCount, w0);

    doWrite(3, 4);
    doRead(3, 4, 1);

    // R7: read continues from stored pointer after STOP
    doRead(0, 1, 0);

    // R8: wrap on write and read
    doWrite(62, 4);
    check("R8 wrapped pointer", regAddr, 2);
    doRead(62, 4, 1);

    // R10: STOP in the middle of a byte
    w0 = wrCount;
    busStart();
    writeByte(8'hD0, ack);
    writeByte(8'd40, ack);
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    busStop();
    check("R10 partial byte discarded", wrCount, w0);
    check("R10 pointer unchanged", regAddr, 40);
    expPtr = 40;

    // R9: repeated START right after the word address, then write
    busStart();
    writeByte(8'hD0, ack);
    writeByte(8'd50, ack);
    busStart();
    writeByte(8'hD0, ack); check("R9 readdress after repeated START", ack, 1);
    writeByte(8'd12, ack); check("R9 new word address ack", ack, 1);
    busStop();
    check("R9 pointer from second phase", regAddr, 12);
    expPtr = 12;

    // R12: glitches on SDA and SCL inside a data byte
    w0 = wrCount;
    busStart();
    writeByte(8'hD0, ack);
    writeByte(8'd20, ack);
    for (int i = 7; i >= 0; i--) begin
      if (i == 5) begin
        sdaM = 1'b1; waitQ(1);
        sclM = 1'b1; waitQ(1);
        sdaM = 1'b0; @(negedge clk); sdaM = 1'b1;
        waitQ(1);
        sclM = 1'b0; waitQ(1);
      end else if (i == 2) begin
        sdaM = 1'b1; waitQ(1);
        sclM = 1'b1; waitQ(1);
        sclM = 1'b0; @(negedge clk); sclM = 1'b1;
        waitQ(1);
        sclM = 1'b0; waitQ(1);
      end else begin
        sendBit(1'b1);
      end
    end
    getAck(ack); check("R12 ack despite glitches", ack, 1);
    busStop();
    expMem[20] = 8'hFF;
    check("R12 one write", wrCount, w0 + 1);
    check("R12 pointer advanced", regAddr, 21);
    expPtr = 21;
    doRead(20, 1, 1);

    // R11: power fail in the same cycle as the write-completing SCL fall
    w0 = wrCount;
    busStart();
    writeByte(8'hD0, ack);
    writeByte(8'd10, ack);
    for (int i = 0; i < 7; i++) sendBit(1'b0);
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(2);
    sclM = 1'b0; powerFail = 1'b1;
    waitQ(2);
    check("R11 no write on abort", wrCount, w0);
    check("R11 pointer cleared", regAddr, 0);
    check("R11 SDA released", sdaDriveLow, 0);
    busStop();
    busStart();
    writeByte(8'hD0, ack); check("R11 bus ignored", ack, 0);
    busStop();
    powerFail = 1'b0;
    waitQ(2);
    expPtr = 0;
    doRead(0, 2, 0);

    // random writes read back
    for (int t = 0; t < 6; t++) begin
      int a, n;
      a = int'($urandom % 64);
      n = 1 + int'($urandom % 5);
      doWrite(a, n);
      doRead(a, n, 1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule